// File: doc/BRIEF.md
# Periodic Timer Interrupt Flag Unit

This block is the interval timer of a small 4-bit microcontroller core. A divider turns the input clock into machine cycles of six clocks each. A 7-bit prescaler then counts those machine cycles and produces a one-clock expiry strobe once every 128 machine cycles, which is 768 input clocks. The timer starts running when reset is released and never stops. On every expiry it restarts by itself.

Each expiry sets a sticky timer request flag. The flag has two uses. The interrupt controller sees it as a request, gated by an enable bit in a 4-bit control register that the core loads from its accumulator. A skip-on-flag instruction can also poll the flag: the poll reports the flag as a skip condition and clears it at the next edge. Every expiry and every control register write also produces a one-clock "recheck" pulse, which tells the interrupt controller to evaluate its requests again.

Top module: `interval_flag_timer`

## Requirements
- R1: While `rst_ni` is low at a rising edge, the unit clears the flag, the control register, `recheck_o` and the counters, so `tmr_flag_o`, `v_reg_o`, `irq_req_o`, `recheck_o` and `skip_o` all read 0.
- R2: A machine cycle is 6 clocks and the prescaler spans 128 machine cycles. Counting rising edges with `rst_ni` high from 1, the flag is still 0 after edge 767 and reads 1 after edge 768.
- R3: The timer runs freely. It expires again at every multiple of 768 edges, whatever the state of the flag, the control register or the poll input.
- R4: An expiry sets `tmr_flag_o`. The flag then stays set until a poll clears it or reset is applied.
- R5: `skip_o` is high in a cycle exactly when `skip_test_i` is high and `tmr_flag_o` is 1 in that same cycle.
- R6: A poll (`skip_test_i` high at an edge) with no expiry at that edge leaves `tmr_flag_o` at 0 after that edge.
- R7: When an expiry and a poll fall on the same edge, the flag is 1 after that edge, so the new event is not lost.
- R8: `v_wr_i` high at an edge loads `v_data_i` into the 4-bit control register, which is visible on `v_reg_o` after that edge. Bit 0 of the register is the timer interrupt enable.
- R9: `irq_req_o` is 1 exactly when `tmr_flag_o` is 1 and bit 0 of `v_reg_o` is 1.
- R10: `recheck_o` is 1 for the single cycle after an edge that had an expiry or a control register write, and 0 otherwise.
- R11: A poll while the flag is 0 gives `skip_o` = 0, and the flag is still 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| v_wr_i | input | 1 | Load strobe for the control register |
| v_data_i | input | 4 | Accumulator value to load into the control register |
| skip_test_i | input | 1 | Test-and-clear poll of the timer flag |
| tmr_flag_o | output | 1 | Timer request flag |
| irq_req_o | output | 1 | Flag gated by the enable bit, sent to the interrupt controller |
| recheck_o | output | 1 | One-cycle pulse: interrupts must be re-evaluated |
| skip_o | output | 1 | Skip condition for the polling instruction |
| v_reg_o | output | 4 | Control register contents |

## Verification
Two events can arrive on the same edge: a prescaler expiry and a test-and-clear poll. The bench counts edges from the release of reset and raises `skip_test_i` for exactly edge 1536, so that the poll lands on the second expiry. The flag must read 1 after that edge. A behavioural model runs in step with the design and computes expiries from the edge count, which separately judges every other cycle of the run. The run also covers a poll that does not coincide with an expiry, a poll made while the flag is 0, and an expiry that arrives while the flag is already set.

// File: rtl/tmr_pkg.sv
// Package: shared defaults and the flag-update action type for the interval timer.
// Assumes: consumers take widths from parameters that default to these values.
package tmr_pkg;
    parameter int unsigned MCYC_CLKS_DEF = 6;   // input clocks per machine cycle
    parameter int unsigned PRESC_W_DEF   = 7;   // prescaler width in bits
    parameter int unsigned VREG_W_DEF    = 4;   // control register width

    // Next-state choice for the request flag
    typedef enum logic [1:0] {
        FLAG_HOLD = 2'd0,
        FLAG_SET  = 2'd1,
        FLAG_CLR  = 2'd2
    } flag_act_e;
endpackage

// File: rtl/mcyc_divider.sv
// Module: mcyc_divider
// Divides the input clock into machine cycles. mcyc_stb_o is high for one
// clock at the end of every MCYC_CLKS clocks.
// Assumes: MCYC_CLKS >= 2; synchronous active-low reset.
module mcyc_divider #(
    parameter int unsigned MCYC_CLKS = tmr_pkg::MCYC_CLKS_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic mcyc_stb_o
);
    localparam int unsigned DIV_W = (MCYC_CLKS > 1) ? $clog2(MCYC_CLKS) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(MCYC_CLKS - 1);

    logic [DIV_W-1:0] div_q;

    // Count input clocks modulo MCYC_CLKS
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    // Strobe on the final clock of each machine cycle
    always_comb begin
        mcyc_stb_o = (div_q == LAST);
    end
endmodule

// File: rtl/cycle_prescaler.sv
// Module: cycle_prescaler
// A free-running PRESC_W-bit counter of machine-cycle strobes. expire_o is a
// single-clock strobe when the counter wraps from all ones to zero.
// Assumes: mcyc_stb_i is a one-clock strobe; synchronous active-low reset.
module cycle_prescaler #(
    parameter int unsigned PRESC_W = tmr_pkg::PRESC_W_DEF
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mcyc_stb_i,
    output logic expire_o
);
    logic [PRESC_W-1:0] presc_q;

    // Advance one step per machine cycle and wrap naturally
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            presc_q <= '0;
        end else if (mcyc_stb_i) begin
            presc_q <= presc_q + PRESC_W'(1);
        end
    end

    // Expiry: the last machine cycle of a full prescaler span
    always_comb begin
        expire_o = mcyc_stb_i && (&presc_q);
    end
endmodule

// File: rtl/tmr_flag_ctrl.sv
// Module: tmr_flag_ctrl
// Holds the timer request flag, the control register and the recheck pulse.
// An expiry takes priority over a poll on the same edge. skip_o is the
// flag as seen by a poll in the current cycle.
// Assumes: expire_i is a one-clock strobe; synchronous active-low reset.
module tmr_flag_ctrl
    import tmr_pkg::*;
#(
    parameter int unsigned VREG_W = VREG_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              expire_i,
    input  logic              skip_test_i,
    input  logic              v_wr_i,
    input  logic [VREG_W-1:0] v_data_i,
    output logic              flag_o,
    output logic              skip_o,
    output logic              irq_req_o,
    output logic              recheck_o,
    output logic [VREG_W-1:0] v_reg_o
);
    flag_act_e         act;
    logic              flag_q;
    logic              recheck_q;
    logic [VREG_W-1:0] v_q;

    // Choose the flag action; an expiry outranks a clearing poll
    always_comb begin
        if (expire_i) begin
            act = FLAG_SET;
        end else if (skip_test_i) begin
            act = FLAG_CLR;
        end else begin
            act = FLAG_HOLD;
        end
    end

    // Flag register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flag_q <= 1'b0;
        end else begin
            unique case (act)
                FLAG_SET: flag_q <= 1'b1;
                FLAG_CLR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end

    // Control register loaded from the accumulator
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            v_q <= '0;
        end else if (v_wr_i) begin
            v_q <= v_data_i;
        end
    end

    // Recheck pulse after any event that may change the interrupt picture
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            recheck_q <= 1'b0;
        end else begin
            recheck_q <= expire_i || v_wr_i;
        end
    end

    // Outputs
    always_comb begin
        flag_o    = flag_q;
        skip_o    = skip_test_i && flag_q;
        irq_req_o = flag_q && v_q[0];
        recheck_o = recheck_q;
        v_reg_o   = v_q;
    end
endmodule

// File: rtl/interval_flag_timer.sv
// Module: interval_flag_timer (top)
// Free-running interval timer: clock divider -> prescaler -> request flag.
// Assumes: synchronous active-low reset; one poll and one register write at most per clock.
module interval_flag_timer #(
    parameter int unsigned MCYC_CLKS = tmr_pkg::MCYC_CLKS_DEF,
    parameter int unsigned PRESC_W   = tmr_pkg::PRESC_W_DEF,
    parameter int unsigned VREG_W    = tmr_pkg::VREG_W_DEF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              v_wr_i,
    input  logic [VREG_W-1:0] v_data_i,
    input  logic              skip_test_i,
    output logic              tmr_flag_o,
    output logic              irq_req_o,
    output logic              recheck_o,
    output logic              skip_o,
    output logic [VREG_W-1:0] v_reg_o
);
    logic mcyc_stb;
    logic expire_stb;

    // Machine-cycle divider
    mcyc_divider #(.MCYC_CLKS(MCYC_CLKS)) div_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mcyc_stb_o (mcyc_stb)
    );

    // Machine-cycle prescaler
    cycle_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mcyc_stb_i (mcyc_stb),
        .expire_o   (expire_stb)
    );

    // Flag, control register and recheck pulse
    tmr_flag_ctrl #(.VREG_W(VREG_W)) ctrl_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .expire_i    (expire_stb),
        .skip_test_i (skip_test_i),
        .v_wr_i      (v_wr_i),
        .v_data_i    (v_data_i),
        .flag_o      (tmr_flag_o),
        .skip_o      (skip_o),
        .irq_req_o   (irq_req_o),
        .recheck_o   (recheck_o),
        .v_reg_o     (v_reg_o)
    );
endmodule

// File: rtl/interval_flag_timer_chk.sv
// Module: interval_flag_timer_chk
// Assertion checker bound to interval_flag_timer. It watches the ports and
// the two internal strobes. A counter checks the expiry spacing, so that no
// deep $past is needed.
module interval_flag_timer_chk #(
    parameter int unsigned MCYC_CLKS = 6,
    parameter int unsigned PRESC_W   = 7,
    parameter int unsigned VREG_W    = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              mcyc_stb,
    input logic              expire_stb,
    input logic              skip_test_i,
    input logic              v_wr_i,
    input logic [VREG_W-1:0] v_data_i,
    input logic              tmr_flag_o,
    input logic              recheck_o,
    input logic              skip_o,
    input logic [VREG_W-1:0] v_reg_o
);
    localparam int unsigned PERIOD = MCYC_CLKS * (2 ** PRESC_W);

    int unsigned gap_q;

    // Clocks elapsed since reset or since the last expiry
    always_ff @(posedge clk_i) begin
        if (!rst_ni || expire_stb) begin
            gap_q <= 0;
        end else begin
            gap_q <= gap_q + 1;
        end
    end

    // R2
    expire_on_mcyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_stb |-> mcyc_stb);

    // R3
    expire_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_stb |-> (gap_q == PERIOD - 1));

    // R4
    flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_stb |=> tmr_flag_o);

    // R4
    flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tmr_flag_o && !expire_stb) |=> !tmr_flag_o);

    // R5
    skip_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        skip_o |-> (tmr_flag_o && skip_test_i));

    // R6
    poll_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (skip_test_i && !expire_stb) |=> !tmr_flag_o);

    // R8
    vreg_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_wr_i |=> (v_reg_o == $past(v_data_i)));

    // R10
    recheck_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_stb || v_wr_i) |=> recheck_o);

    // R10
    recheck_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(expire_stb || v_wr_i) |=> !recheck_o);
endmodule

bind interval_flag_timer interval_flag_timer_chk #(
    .MCYC_CLKS(MCYC_CLKS), .PRESC_W(PRESC_W), .VREG_W(VREG_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mcyc_stb    (mcyc_stb),
    .expire_stb  (expire_stb),
    .skip_test_i (skip_test_i),
    .v_wr_i      (v_wr_i),
    .v_data_i    (v_data_i),
    .tmr_flag_o  (tmr_flag_o),
    .recheck_o   (recheck_o),
    .skip_o      (skip_o),
    .v_reg_o     (v_reg_o)
);

// File: tb/interval_flag_timer_tb_top.sv
// Bench: behavioural reference model compared on every clock, plus directed checks.
module interval_flag_timer_tb_top;
    localparam int PERIOD = 6 * 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       v_wr = 1'b0;
    logic [3:0] v_data = 4'd0;
    logic       skip_test = 1'b0;
    logic       flag, irq, rechk, skip;
    logic [3:0] vreg;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit started = 1'b0;

    // Reference model state
    int       m_n = 0;
    bit       m_flag = 1'b0;
    bit       m_rec = 1'b0;
    bit [3:0] m_v = 4'd0;

    always #4 clk = ~clk;   // 125 MHz

    interval_flag_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .v_wr_i      (v_wr),
        .v_data_i    (v_data),
        .skip_test_i (skip_test),
        .tmr_flag_o  (flag),
        .irq_req_o   (irq),
        .recheck_o   (rechk),
        .skip_o      (skip),
        .v_reg_o     (vreg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at edge %0d", tag, act, exp, m_n);
        end
    endtask

    // Reference model: advance on every rising edge
    always @(posedge clk) begin
        bit exp_now;
        started = 1'b1;
        if (!rst_n) begin
            m_n = 0; m_flag = 1'b0; m_v = 4'd0; m_rec = 1'b0;
        end else begin
            m_n++;
            exp_now = (m_n % PERIOD) == 0;
            m_rec = exp_now || v_wr;
            if (v_wr) m_v = v_data;
            if (exp_now) m_flag = 1'b1;
            else if (skip_test) m_flag = 1'b0;
        end
    end

    // Compare every cycle, away from both clock edges
    always @(negedge clk) begin
        #2;
        if (started && !done) begin
            chk(flag == m_flag, "R4 flag", flag, m_flag);
            chk(vreg == m_v, "R8 vreg", vreg, m_v);
            chk(irq == (m_flag && m_v[0]), "R9 irq", irq, m_flag && m_v[0]);
            chk(rechk == m_rec, "R10 recheck", rechk, m_rec);
            chk(skip == (skip_test && m_flag), "R5 skip", skip, skip_test && m_flag);
        end
    end

    task automatic goto_edge(input int k);
        while (m_n != k) @(negedge clk);
    endtask

    // Directed sequence
    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(flag == 1'b0 && vreg == 4'd0 && irq == 1'b0 && rechk == 1'b0 && skip == 1'b0,
            "R1 reset", {flag, vreg, irq, rechk}, 0);
        rst_n = 1'b1;
        goto_edge(9);  v_wr = 1'b1; v_data = 4'd1;
        goto_edge(10); v_wr = 1'b0;
        chk(vreg == 4'd1, "R8 load", vreg, 1);
        goto_edge(767);
        chk(flag == 1'b0, "R2 before expiry", flag, 0);
        goto_edge(768);
        chk(flag == 1'b1, "R2 first expiry", flag, 1);
        chk(irq == 1'b1, "R9 enabled request", irq, 1);
        goto_edge(799); skip_test = 1'b1;
        #2 chk(skip == 1'b1, "R5 poll sees flag", skip, 1);
        goto_edge(800); skip_test = 1'b0;
        chk(flag == 1'b0, "R6 poll clears", flag, 0);
        goto_edge(819); skip_test = 1'b1;
        #2 chk(skip == 1'b0, "R11 poll on clear flag", skip, 0);
        goto_edge(820); skip_test = 1'b0;
        chk(flag == 1'b0, "R11 flag stays clear", flag, 0);
        goto_edge(1535); skip_test = 1'b1;
        goto_edge(1536); skip_test = 1'b0;
        chk(flag == 1'b1, "R7 expiry beats poll", flag, 1);
        goto_edge(1599); v_wr = 1'b1; v_data = 4'hA;
        goto_edge(1600); v_wr = 1'b0;
        chk(rechk == 1'b1, "R10 recheck on write", rechk, 1);
        chk(irq == 1'b0, "R9 disabled request", irq, 0);
        goto_edge(2304);
        chk(flag == 1'b1, "R3 expiry while set", flag, 1);
        chk(rechk == 1'b1, "R10 recheck on expiry", rechk, 1);
        goto_edge(2399); skip_test = 1'b1;
        goto_edge(2400); skip_test = 1'b0;
        chk(flag == 1'b0, "R6 second clear", flag, 0);
        goto_edge(3071);
        chk(flag == 1'b0, "R3 before third expiry", flag, 0);
        goto_edge(3072);
        chk(flag == 1'b1, "R3 periodic expiry", flag, 1);
        goto_edge(3080);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", m_n, 3080);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule